// File: doc/BRIEF.md
# Masked SIMD GF(2^8) Byte Multiplier

This block multiplies two wide vectors byte by byte, treating each byte as an element of the finite field GF(2^8). The field is reduced by the polynomial x^8 + x^4 + x^3 + x + 1 (0x11B). Every byte lane is independent of the others. No operand is shared or broadcast across lanes.

A 2-bit length code sets how many lanes are active: 16, 32 or 64. A per-lane write mask decides which active lanes take the product. When masking is on, each lane whose mask bit is clear takes one of two values. Under the zeroing policy the lane becomes zero. Under the merge policy it keeps the byte from the previous destination. Every result bit above the active length is cleared.

A legacy flag selects a fixed two-operand form. In this form the previous destination acts as the first source, exactly 16 lanes are computed, and the mask is not applied. The result and its valid are registered, so each result appears one clock after its inputs.

Top module: `gfm_vec_mul`

## Requirements
- R1: Each active, written lane holds the product of its two operand bytes. The product is formed by XOR-accumulating the first byte shifted left by every set bit position of the second byte. It is then reduced by XORing 0x11B << (k-8) for each set accumulator bit k, scanned from 14 down to 8. The result is the low byte, so 0x53·0xCA = 0x01 and 0x02·0x80 = 0x1B.
- R2: A lane whose operand byte is 0x00 (either operand) produces 0x00 when written.
- R3: Length code `vlen` maps 2'b00→16 lanes, 2'b01→32 lanes, 2'b10→64 lanes, and the reserved 2'b11→64 lanes. Lane j occupies bits [8j+7:8j].
- R4: Every result bit above the active length is 0, regardless of mask, policy and previous destination.
- R5: With `mask_en` low, every active lane is written with its product and `lane_mask` has no effect.
- R6: With `mask_en` high and `zero_en` high, an active lane whose `lane_mask[j]` is 0 outputs 0x00.
- R7: With `mask_en` high and `zero_en` low, an active lane whose `lane_mask[j]` is 0 outputs byte j of `dst_prev`.
- R8: With `legacy` high, lanes 0..15 hold the product of `dst_prev` byte j (first operand) and `src_b` byte j. The upper bits are 0. `vlen`, `src_a`, `mask_en`, `zero_en` and `lane_mask` have no effect.
- R9: `out_valid` equals `in_valid` of the previous clock. `result` is loaded only on cycles with `in_valid` high and holds otherwise.
- R10: A synchronous active-high `rst` clears `out_valid` and `result` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 512 | First source vector (byte lanes) |
| src_b | input | 512 | Second source vector (byte lanes) |
| dst_prev | input | 512 | Previous destination value for merge and legacy mode |
| lane_mask | input | 64 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | Apply `lane_mask` when high |
| zero_en | input | 1 | Masked-off lanes become zero (high) or merge (low) |
| vlen | input | 2 | Active length code |
| legacy | input | 1 | Fixed 16-lane two-operand form |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 512 | Registered result vector |

## Verification
The lane-0 policy properties compare the output with the control inputs and `dst_prev` as they stood one cycle earlier. They assume those inputs are ordinary two-state values whenever `in_valid` is high. The stimulus always drives every input to a defined value, and it changes inputs only between clock edges.

The hold property assumes `result` is observed only after reset has been released for at least one edge. The driver keeps `rst` asserted for several cycles before issuing the first operation.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_LANES = 64;
    localparam int ACC_W     = 2 * BYTE_W - 1;
    localparam logic [ACC_W-1:0] FIELD_POLY = 15'h011B;

    typedef enum logic [1:0] {
        LEN_16  = 2'b00,
        LEN_32  = 2'b01,
        LEN_64  = 2'b10,
        LEN_RSV = 2'b11
    } len_code_e;

    typedef struct packed {
        logic use_mask;
        logic zero_off;
        logic legacy;
    } lane_policy_t;

    function automatic int active_lanes(input len_code_e code, input logic legacy);
        if (legacy) return 16;
        case (code)
            LEN_16:  return 16;
            LEN_32:  return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [ACC_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ (ACC_W'(a) << i);
        end
        for (int k = ACC_W - 1; k >= BYTE_W; k--) begin
            if (acc[k]) acc = acc ^ (FIELD_POLY << (k - BYTE_W));
        end
        return acc[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/gfm_lane.sv
module gfm_lane
    import gfm_pkg::*;
(
    input  logic [BYTE_W-1:0] op_a,
    input  logic [BYTE_W-1:0] op_b,
    output logic [BYTE_W-1:0] prod
);
    always_comb prod = gf_mul(op_a, op_b);
endmodule

// File: rtl/gfm_lane_sel.sv
module gfm_lane_sel
    import gfm_pkg::*;
(
    input  logic [BYTE_W-1:0] prod,
    input  logic [BYTE_W-1:0] prev,
    input  logic              active,
    input  logic              mask_bit,
    input  lane_policy_t      pol,
    output logic [BYTE_W-1:0] byte_out
);
    logic write_it;

    always_comb begin
        write_it = pol.legacy | ~pol.use_mask | mask_bit;
        if (!active)
            byte_out = '0;
        else if (write_it)
            byte_out = prod;
        else if (pol.zero_off)
            byte_out = '0;
        else
            byte_out = prev;
    end
endmodule

// File: rtl/gfm_vec_mul.sv
module gfm_vec_mul
    import gfm_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] dst_prev,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    mask_en,
    input  logic                    zero_en,
    input  logic [1:0]              vlen,
    input  logic                    legacy,
    output logic                    out_valid,
    output logic [LANES*BYTE_W-1:0] result
);
    localparam int VEC_W = LANES * BYTE_W;

    lane_policy_t     pol;
    int               n_act;
    logic [VEC_W-1:0] next_vec;

    always_comb begin
        pol.use_mask = mask_en;
        pol.zero_off = zero_en;
        pol.legacy   = legacy;
        n_act        = active_lanes(len_code_e'(vlen), legacy);
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [BYTE_W-1:0] a_byte;
        logic [BYTE_W-1:0] p_byte;
        logic              act;

        assign a_byte = legacy ? dst_prev[j*BYTE_W +: BYTE_W]
                               : src_a[j*BYTE_W +: BYTE_W];
        assign act    = (j < n_act);

        gfm_lane u_mul (
            .op_a (a_byte),
            .op_b (src_b[j*BYTE_W +: BYTE_W]),
            .prod (p_byte)
        );

        gfm_lane_sel u_sel (
            .prod     (p_byte),
            .prev     (dst_prev[j*BYTE_W +: BYTE_W]),
            .active   (act),
            .mask_bit (lane_mask[j]),
            .pol      (pol),
            .byte_out (next_vec[j*BYTE_W +: BYTE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_vec;
        end
    end
endmodule

// File: rtl/gfm_vec_mul_chk.sv
module gfm_vec_mul_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [511:0] src_b,
    input logic [511:0] dst_prev,
    input logic [63:0]  lane_mask,
    input logic         mask_en,
    input logic         zero_en,
    input logic [1:0]   vlen,
    input logic         legacy,
    input logic         out_valid,
    input logic [511:0] result
);
    // R9: valid follows input valid by one clock
    assert_valid_lat_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R9: result holds on idle cycles
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(result));

    // R10: reset clears valid and result
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R4: bits above 128 zero for short length or legacy form
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst) && ($past(legacy) || $past(vlen) == 2'b00))
        |-> result[511:128] == '0);

    // R6: zeroing policy on masked-off lane 0
    assert_zeroing_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst) && !$past(legacy) && $past(mask_en)
         && $past(zero_en) && !$past(lane_mask[0])) |-> result[7:0] == 8'h00);

    // R7: merge policy on masked-off lane 0
    assert_merge_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst) && !$past(legacy) && $past(mask_en)
         && !$past(zero_en) && !$past(lane_mask[0])) |-> result[7:0] == $past(dst_prev[7:0]));

    // R2: zero second operand in written lane 0 yields zero
    assert_zero_operand_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst) && !$past(mask_en) && $past(src_b[7:0]) == 8'h00)
        |-> result[7:0] == 8'h00);
endmodule

bind gfm_vec_mul gfm_vec_mul_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_b     (src_b),
    .dst_prev  (dst_prev),
    .lane_mask (lane_mask),
    .mask_en   (mask_en),
    .zero_en   (zero_en),
    .vlen      (vlen),
    .legacy    (legacy),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_gfm_vec_mul.sv
module test_gfm_vec_mul;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src_a = '0, src_b = '0, dst_prev = '0;
    logic [63:0]  lane_mask = '0;
    logic         mask_en = 1'b0, zero_en = 1'b0, legacy = 1'b0;
    logic [1:0]   vlen = 2'b00;
    logic         out_valid;
    logic [511:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [511:0] exp_q[$];
    string        tag_q[$];
    logic [511:0] last_exp = '0;

    always #10 clk = ~clk;   // 50 MHz

    gfm_vec_mul i_gfm_vec_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .dst_prev(dst_prev), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_en(zero_en), .vlen(vlen), .legacy(legacy),
        .out_valid(out_valid), .result(result)
    );

    // independent reference: shift-and-add with per-step reduction
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x, y, acc;
        x = a; y = b; acc = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) acc ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
            y = y >> 1;
        end
        return acc;
    endfunction

    function automatic logic [511:0] model(input logic [511:0] a, input logic [511:0] b,
                                           input logic [511:0] d, input logic [63:0] m,
                                           input logic me, input logic ze,
                                           input logic [1:0] vl, input logic lg);
        logic [511:0] r;
        int n;
        r = '0;
        n = lg ? 16 : (vl == 2'b00) ? 16 : (vl == 2'b01) ? 32 : 64;
        for (int j = 0; j < n; j++) begin
            if (lg)
                r[j*8 +: 8] = ref_mul(d[j*8 +: 8], b[j*8 +: 8]);
            else if (!me || m[j])
                r[j*8 +: 8] = ref_mul(a[j*8 +: 8], b[j*8 +: 8]);
            else
                r[j*8 +: 8] = ze ? 8'h00 : d[j*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic drive(input string tag, input logic [511:0] a, input logic [511:0] b,
                         input logic [511:0] d, input logic [63:0] m, input logic me,
                         input logic ze, input logic [1:0] vl, input logic lg);
        @(negedge clk);
        src_a = a; src_b = b; dst_prev = d; lane_mask = m;
        mask_en = me; zero_en = ze; vlen = vl; legacy = lg; in_valid = 1'b1;
        exp_q.push_back(model(a, b, d, m, me, ze, vl, lg));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a = rnd512(); src_b = rnd512(); dst_prev = rnd512();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected valid", 512'd1, 512'd0);
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), result, last_exp);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [511:0] a, b, d;
        repeat (4) @(negedge clk);
        check("R10 reset result", result, '0);
        check("R10 reset valid", {511'd0, out_valid}, '0);
        rst = 1'b0;

        // R1 known products in lanes 0 and 1, hard expected values
        a = rnd512(); b = rnd512(); d = rnd512();
        a[7:0] = 8'h53; b[7:0] = 8'hCA; a[15:8] = 8'h02; b[15:8] = 8'h80;
        @(negedge clk);
        src_a = a; src_b = b; dst_prev = d; lane_mask = '0; mask_en = 0;
        zero_en = 0; vlen = 2'b10; legacy = 0; in_valid = 1;
        begin
            logic [511:0] e;
            e = model(a, b, d, '0, 0, 0, 2'b10, 0);
            e[7:0] = 8'h01; e[15:8] = 8'h1B;
            exp_q.push_back(e); tag_q.push_back("R1 known products");
        end
        drive("R1 random full", rnd512(), rnd512(), rnd512(), '0, 0, 0, 2'b10, 0);
        // R2 zero operands
        a = rnd512(); b = rnd512();
        for (int j = 0; j < 64; j += 3) b[j*8 +: 8] = 8'h00;
        for (int j = 1; j < 64; j += 5) a[j*8 +: 8] = 8'h00;
        drive("R2 zero operand", a, b, rnd512(), '0, 0, 0, 2'b10, 0);
        // R3/R4 lengths
        drive("R3 R4 len16", rnd512(), rnd512(), rnd512(), {64{1'b1}}, 1, 0, 2'b00, 0);
        drive("R3 R4 len32", rnd512(), rnd512(), rnd512(), {64{1'b1}}, 1, 0, 2'b01, 0);
        drive("R3 len64 code", rnd512(), rnd512(), rnd512(), '0, 0, 1, 2'b10, 0);
        drive("R3 reserved code", rnd512(), rnd512(), rnd512(), '0, 0, 1, 2'b11, 0);
        // R5 mask disabled with mask all zero
        drive("R5 mask off", rnd512(), rnd512(), rnd512(), '0, 0, 1, 2'b10, 0);
        // R6 zeroing
        drive("R6 zeroing", rnd512(), rnd512(), rnd512(), {$urandom, $urandom}, 1, 1, 2'b10, 0);
        drive("R6 R4 zeroing len32", rnd512(), rnd512(), rnd512(), {$urandom, $urandom}, 1, 1, 2'b01, 0);
        // R7 merge
        drive("R7 merge", rnd512(), rnd512(), rnd512(), {$urandom, $urandom}, 1, 0, 2'b10, 0);
        drive("R7 R4 merge len16", rnd512(), rnd512(), rnd512(), 64'h0, 1, 0, 2'b00, 0);
        // R8 legacy: mask, zeroing and length all set to matter if not ignored
        drive("R8 legacy", rnd512(), rnd512(), rnd512(), 64'h0, 1, 1, 2'b10, 1);
        drive("R8 legacy merge", rnd512(), rnd512(), rnd512(), 64'h0, 1, 0, 2'b11, 1);
        for (int t = 0; t < 20; t++)
            drive("R1 R5 R6 R7 mix", rnd512(), rnd512(), rnd512(), {$urandom, $urandom},
                  1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom & 1 & (t % 4 == 0)));

        // R9 idle: no valid, result holds
        idle();
        repeat (3) begin
            idle();
            check("R9 idle valid", {511'd0, out_valid}, '0);
            check("R9 hold result", result, last_exp);
        end
        check("R9 queue drained", 512'(exp_q.size()), '0);

        // R10 reset after activity
        drive("R10 pre-reset", rnd512(), rnd512(), rnd512(), '0, 0, 0, 2'b10, 0);
        idle();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 reset result again", result, '0);
        check("R10 reset valid again", {511'd0, out_valid}, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule